// File: doc/BRIEF.md
# Block-Framed Serial Receiver with Locked Host Buffer

This block receives asynchronous serial characters and hands them to a host in groups. The line is oversampled at 16 times the bit rate, and each bit is decided by a two-of-three vote among the samples nearest its centre. Assembled characters go into a small host buffer, by default four bytes deep. A programmable block length of m+1 bytes, with m from 0 to 63, sets how the bytes are grouped.

The buffer is released to the host only when it has filled, or when the last byte of a block has arrived. It then stays locked until the host has drained every byte. A character that completes while the buffer is locked is dropped and reported as an overrun. Parity and framing problems are flagged, but the byte is kept. With CRC checking on, each block ends with two check bytes. These bytes are compared against a CRC-CCITT value and never reach the host. All four error flags stay set until the host pulses an error-clear input.

Top module: `block_uart_rx`

## Requirements
- R1: Each bit is decided by a majority of three samples taken at oversampling ticks 7, 8 and 9 after the bit start. A single disturbed sample among them does not change the received value.
- R2: A falling edge whose centre majority is 1 is discarded as a false start. No character results, and the receiver returns to waiting for a new edge.
- R3: A character frame is one low start bit, then 8 data bits with the least significant bit first, then one parity bit if parity is on, then a stop bit. Each bit lasts 16 `os_tick` pulses.
- R4: `buf_full` sets when the fourth byte enters the buffer. This can only happen in a block longer than 3 bytes.
- R5: `pkt_end` sets when byte m+1 of a block enters the buffer, with m taken from `cfg_len_m`. When m+1 is a multiple of 4, `buf_full` and `pkt_end` set together.
- R6: A `rd_stb` while neither flag is set has no effect. While the buffer is locked, each `rd_stb` pops the oldest byte, and the byte appears on `rd_data` one clock later. Popping the last byte clears both flags.
- R7: A data character that completes while the buffer is locked is discarded, and `err_ovr` is set.
- R8: When parity is on, `cfg_par_odd`=0 selects even parity and 1 selects odd parity. A parity mismatch sets `err_par`. A stop bit sampled as 0 sets `err_frm`. In both cases the byte is still stored.
- R9: CRC checking is on when `cfg_crc_en`=1 and `cfg_par_en`=0; parity wins when both are set. The CRC is CRC-CCITT: polynomial 0x1021, preset 0xFFFF, each data byte processed most significant bit first. Two check bytes follow the data, high byte first. They do not enter the buffer and are accepted even while the buffer is locked. A mismatch sets `err_crc`.
- R10: The four error flags are sticky. A one-cycle `err_clr` pulse clears all of them on the next clock.
- R11: While `rx_en`=0 the receiver stays idle, and no character is produced.
- R12: `irq` is high exactly while `buf_full` or `pkt_end` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| cfg_len_m | input | 6 | Block length minus one |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_crc_en | input | 1 | Block check bytes present and checked |
| err_clr | input | 1 | Pulse that clears the error flags |
| rd_stb | input | 1 | Byte-read strobe |
| rd_data | output | 8 | Byte popped by the last accepted strobe |
| buf_full | output | 1 | Four bytes of the current block are waiting |
| pkt_end | output | 1 | Last byte of the block is waiting |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun |
| err_crc | output | 1 | Sticky block check mismatch |
| irq | output | 1 | Host attention request |

## Verification
The bench aims at the lock boundaries:
- A strobe sent before the buffer is released must not pop anything. A design that let it through would return the second byte on the first legal read.
- A fifth byte arriving during `buf_full` must be dropped. A design that stored it would corrupt the buffer and shift the block count.
- When the block length is a multiple of four, both flags must rise on the same byte. A design that missed this would raise only one of them.

It also sends check bytes while the buffer is locked, which a design that treated them as data would flag as an overrun. It sends one-tick glitches at bit centres and short false starts, which a voter that trusted a single sample would turn into wrong bytes or phantom characters.

// File: rtl/blkrx_pkg.sv
package blkrx_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_char_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/blkrx_sampler.sv
module blkrx_sampler
  import blkrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     en,
  input  logic     rxd,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     vld,
  output rx_char_t chr
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [1:0]    sync;
  logic          act;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic          v0, v1, pbit;
  logic [7:0]    sh;
  logic          maj;
  logic [3:0]    last_bit;

  assign maj      = (v0 & v1) | (v0 & sync[1]) | (v1 & sync[1]);
  assign last_bit = par_en ? 4'd10 : 4'd9;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      act  <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      v0   <= 1'b1;
      v1   <= 1'b1;
      pbit <= 1'b0;
      sh   <= '0;
      vld  <= 1'b0;
      chr  <= '0;
    end else begin
      sync <= {sync[0], rxd};
      vld  <= 1'b0;
      if (!en) begin
        act <= 1'b0;
      end else if (tick) begin
        if (!act) begin
          if (!sync[1]) begin
            act  <= 1'b1;
            cnt  <= '0;
            bitn <= '0;
          end
        end else begin
          cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
          if (cnt == CW'(OSR - 1)) bitn <= bitn + 1'b1;
          if (cnt == CW'(MID - 1)) v0 <= sync[1];
          if (cnt == CW'(MID))     v1 <= sync[1];
          if (cnt == CW'(MID + 1)) begin
            if (bitn == 4'd0) begin
              if (maj) act <= 1'b0;          // false start
            end else if (bitn <= 4'd8) begin
              sh <= {maj, sh[7:1]};
            end else if (bitn == last_bit) begin
              act      <= 1'b0;
              vld      <= 1'b1;
              chr.data <= sh;
              chr.ferr <= ~maj;
              chr.perr <= par_en & ((^sh) ^ pbit ^ par_odd);
            end else begin
              pbit <= maj;
            end
          end
        end
      end
    end
  end

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !vld);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);
endmodule

// File: rtl/blkrx_crc16.sv
module blkrx_crc16
  import blkrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (upd)    crc <= crc_step(crc, din);
  end

  assert_seed_after_init_R9: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc == CRC_SEED));
endmodule

// File: rtl/blkrx_pktbuf.sv
module blkrx_pktbuf
  import blkrx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  rx_char_t         chr,
  input  logic [LEN_W-1:0] len_m,
  input  logic             crc_on,
  input  logic [15:0]      crc,
  input  logic             rd_stb,
  input  logic             err_clr,
  output logic             crc_init,
  output logic             crc_upd,
  output logic [7:0]       rd_data,
  output logic             buf_full,
  output logic             pkt_end,
  output logic             err_par,
  output logic             err_frm,
  output logic             err_ovr,
  output logic             err_crc
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [FW-1:0]    fill;
  logic [PW-1:0]    rptr;
  logic [LEN_W-1:0] bidx;
  logic [1:0]       chk;
  logic [7:0]       chk_hi;

  logic locked, in_chk, store, last, pop, mismatch;
  assign locked   = buf_full | pkt_end;
  assign in_chk   = (chk != 2'd0);
  assign store    = vld & ~in_chk & ~locked;
  assign last     = (bidx == len_m);
  assign pop      = rd_stb & locked & (fill != '0);
  assign mismatch = ({chk_hi, chr.data} != crc);
  assign crc_upd  = store & crc_on;
  assign crc_init = ~crc_on | (vld & (chk == 2'd2));

  always_ff @(posedge clk) begin
    if (store) mem[fill[PW-1:0]] <= chr.data;
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0; rptr <= '0; bidx <= '0; chk <= '0; chk_hi <= '0;
      buf_full <= 1'b0; pkt_end <= 1'b0;
      err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0; err_crc <= 1'b0;
    end else begin
      if (store) begin
        fill <= fill + 1'b1;
        if (fill == FW'(DEPTH - 1)) buf_full <= 1'b1;
        if (last) begin
          pkt_end <= 1'b1;
          bidx    <= '0;
          if (crc_on) chk <= 2'd1;
        end else begin
          bidx <= bidx + 1'b1;
        end
      end else if (pop) begin
        fill <= fill - 1'b1;
        rptr <= rptr + 1'b1;
        if (fill == FW'(1)) begin
          buf_full <= 1'b0;
          pkt_end  <= 1'b0;
          rptr     <= '0;
        end
      end
      if (vld && in_chk) begin
        if (chk == 2'd1) begin
          chk_hi <= chr.data;
          chk    <= 2'd2;
        end else begin
          chk <= 2'd0;
        end
      end
      if (err_clr) begin
        err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0; err_crc <= 1'b0;
      end else begin
        if (vld && chr.perr) err_par <= 1'b1;
        if (vld && chr.ferr) err_frm <= 1'b1;
        if (vld && !in_chk && locked) err_ovr <= 1'b1;
        if (vld && chk == 2'd2 && mismatch) err_crc <= 1'b1;
      end
    end
  end

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH));
  assert_full_on_store_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> $past(store));
  assert_lock_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    locked |-> (fill != '0));
  assert_no_read_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !locked) |=> $stable(rd_data));
  assert_overrun_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (vld && !in_chk && locked && !rd_stb && !err_clr) |=> (err_ovr && $stable(fill)));
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> !(err_par | err_frm | err_ovr | err_crc));
endmodule

// File: rtl/block_uart_rx.sv
module block_uart_rx
  import blkrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 4,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             rx_en,
  input  logic             rxd,
  input  logic [LEN_W-1:0] cfg_len_m,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_crc_en,
  input  logic             err_clr,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  output logic             buf_full,
  output logic             pkt_end,
  output logic             err_par,
  output logic             err_frm,
  output logic             err_ovr,
  output logic             err_crc,
  output logic             irq
);
  logic        chr_vld, crc_on, crc_init, crc_upd;
  rx_char_t    chr;
  logic [15:0] crc;

  assign crc_on = cfg_crc_en & ~cfg_par_en;   // parity takes priority

  blkrx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst(rst), .tick(os_tick), .en(rx_en), .rxd(rxd),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .vld(chr_vld), .chr(chr)
  );

  blkrx_crc16 u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .upd(crc_upd), .din(chr.data), .crc(crc)
  );

  blkrx_pktbuf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst(rst), .vld(chr_vld), .chr(chr), .len_m(cfg_len_m),
    .crc_on(crc_on), .crc(crc), .rd_stb(rd_stb), .err_clr(err_clr),
    .crc_init(crc_init), .crc_upd(crc_upd), .rd_data(rd_data),
    .buf_full(buf_full), .pkt_end(pkt_end), .err_par(err_par),
    .err_frm(err_frm), .err_ovr(err_ovr), .err_crc(err_crc)
  );

  assign irq = buf_full | pkt_end;

  assert_irq_tracks_flags_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($rose(buf_full) || $rose(pkt_end)));
endmodule

// File: tb/block_uart_rx_tb.sv
`timescale 1ns/1ps
module block_uart_rx_tb;
  logic clk = 0, rst = 1, os_tick = 0, rx_en = 0, rxd = 1;
  logic [5:0] cfg_len_m = 0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_crc_en = 0, err_clr = 0, rd_stb = 0;
  logic [7:0] rd_data;
  logic buf_full, pkt_end, err_par, err_frm, err_ovr, err_crc, irq;
  int errors = 0, checks = 0;
  logic [7:0] blk [64];

  always #2.5 clk = ~clk;

  block_uart_rx u_dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_en(rx_en), .rxd(rxd),
    .cfg_len_m(cfg_len_m), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_crc_en(cfg_crc_en), .err_clr(err_clr), .rd_stb(rd_stb), .rd_data(rd_data),
    .buf_full(buf_full), .pkt_end(pkt_end), .err_par(err_par), .err_frm(err_frm),
    .err_ovr(err_ovr), .err_crc(err_crc), .irq(irq)
  );

  initial forever begin @(negedge clk); os_tick = ~os_tick; end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input bit v, input bit gl);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      rxd = (gl && (c == 16 || c == 17)) ? ~v : v;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pv, input bit stopv, input bit gl);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], gl);
    if (cfg_par_en) drive_bit(pv, 1'b0);
    drive_bit(stopv, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic send_ok(input logic [7:0] d);
    send_frame(d, (^d) ^ cfg_par_odd, 1'b1, 1'b0);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    b = rd_data;
  endtask

  task automatic pulse_clr;
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic run_block(input int m, input string tag);
    int rem = m + 1, base = 0;
    logic [7:0] b;
    cfg_len_m = 6'(m);
    for (int i = 0; i <= m; i++) blk[i] = 8'($urandom);
    while (rem > 0) begin
      int chunk = (rem > 4) ? 4 : rem;
      for (int i = 0; i < chunk; i++) send_ok(blk[base + i]);
      check({tag, " R4 full"}, buf_full, chunk == 4);
      check({tag, " R5 end"}, pkt_end, rem == chunk);
      check({tag, " R12 irq"}, irq, 1);
      for (int i = 0; i < chunk; i++) begin
        rd_byte(b);
        check({tag, " R6 data"}, b, blk[base + i]);
      end
      check({tag, " R6 unlock"}, {buf_full, pkt_end}, 0);
      rem -= chunk; base += chunk;
    end
    check({tag, " R8 no err"}, {err_par, err_frm, err_ovr}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b, d0, d1, d2;
    logic [15:0] c;
    int seed;
    seed = $urandom(32'h5eed1234);
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("reset flags", {buf_full, pkt_end, err_par, err_frm, err_ovr, err_crc, irq}, 0);
    check("reset data", rd_data, 0);

    // R11: disabled receiver ignores a frame
    send_ok(8'hA5);
    check("R11 no char while off", {pkt_end, irq}, 0);
    rx_en = 1;

    // R3 R5 R12 single-byte block
    cfg_len_m = 0;
    send_ok(8'h3C);
    check("R5 pkt_end m=0", pkt_end, 1);
    check("R4 no full m=0", buf_full, 0);
    check("R12 irq", irq, 1);
    rd_byte(b);
    check("R3 data", b, 8'h3C);
    check("R12 irq low after drain", irq, 0);

    // R6: read before release is ignored
    cfg_len_m = 2;
    send_ok(8'h11);
    @(negedge clk); rd_stb = 1; @(negedge clk); rd_stb = 0;
    check("R6 early read ignored", rd_data, 8'h3C);
    send_ok(8'h22); send_ok(8'h33);
    check("R5 end m=2", pkt_end, 1);
    rd_byte(d0); rd_byte(d1); rd_byte(d2);
    check("R6 order", {d0, d1, d2}, 24'h112233);

    // R4 R7: block of 6, overrun during full
    cfg_len_m = 5;
    send_ok(8'h01); send_ok(8'h02); send_ok(8'h03); send_ok(8'h04);
    check("R4 full m=5", {buf_full, pkt_end}, 2'b10);
    send_ok(8'hEE);
    check("R7 overrun", err_ovr, 1);
    for (int i = 0; i < 4; i++) begin rd_byte(b); check("R7 buffer intact", b, 8'(i + 1)); end
    send_ok(8'h05); send_ok(8'h06);
    check("R5 tail end", {buf_full, pkt_end}, 2'b01);
    rd_byte(d0); rd_byte(d1);
    check("R7 dropped byte absent", {d0, d1}, 16'h0506);
    pulse_clr;
    check("R10 clear ovr", err_ovr, 0);

    // R5: multiple of four raises both
    cfg_len_m = 3;
    for (int i = 0; i < 4; i++) send_ok(8'h40 + 8'(i));
    check("R5 both flags", {buf_full, pkt_end}, 2'b11);
    for (int i = 0; i < 4; i++) begin rd_byte(b); check("R5 data", b, 8'h40 + 8'(i)); end

    // R8 parity and framing
    cfg_len_m = 0; cfg_par_en = 1; cfg_par_odd = 1;
    send_ok(8'h5A);
    check("R8 good odd parity", err_par, 0);
    rd_byte(b);
    send_frame(8'h5B, ~((^8'h5B) ^ 1'b1), 1'b1, 1'b0);
    check("R8 bad parity flag", err_par, 1);
    rd_byte(b);
    check("R8 stored on parity error", b, 8'h5B);
    cfg_par_odd = 0;
    send_frame(8'h77, ^8'h77, 1'b0, 1'b0);
    check("R8 framing flag", err_frm, 1);
    rd_byte(b);
    check("R8 stored on framing error", b, 8'h77);
    check("R10 sticky before clear", {err_par, err_frm}, 2'b11);
    pulse_clr;
    check("R10 cleared", {err_par, err_frm, err_ovr, err_crc}, 0);
    cfg_par_en = 0;

    // R9 CRC blocks
    cfg_crc_en = 1;
    for (int k = 0; k < 3; k++) begin
      int m = k + 1;
      cfg_len_m = 6'(m);
      c = 16'hFFFF;
      for (int i = 0; i <= m; i++) begin blk[i] = 8'($urandom); c = ref_crc(c, blk[i]); send_ok(blk[i]); end
      if (k == 2) c[0] = ~c[0];
      send_ok(c[15:8]); send_ok(c[7:0]);
      check("R9 crc flag", err_crc, k == 2);
      check("R9 check bytes not overrun", err_ovr, 0);
      for (int i = 0; i <= m; i++) begin rd_byte(b); check("R9 data", b, blk[i]); end
      check("R9 check bytes not buffered", {buf_full, pkt_end}, 0);
    end
    pulse_clr;
    cfg_crc_en = 0;

    // R1: one disturbed centre sample per data bit
    cfg_len_m = 0;
    for (int k = 0; k < 4; k++) begin
      d0 = 8'($urandom);
      send_frame(d0, 1'b0, 1'b1, 1'b1);
      rd_byte(b);
      check("R1 majority vote", b, d0);
    end

    // R2: short low pulse is a false start
    for (int c2 = 0; c2 < 6; c2++) begin @(negedge clk); rxd = 0; end
    for (int c2 = 0; c2 < 400; c2++) begin @(negedge clk); rxd = 1; end
    check("R2 false start no char", {pkt_end, err_frm}, 0);
    send_ok(8'hC3);
    rd_byte(b);
    check("R2 next frame intact", b, 8'hC3);

    // random blocks
    for (int n = 0; n < 25; n++) begin
      cfg_par_en = 1'($urandom);
      cfg_par_odd = 1'($urandom);
      run_block(int'($urandom_range(0, 9)), "rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule